// File: doc/BRIEF.md
# Wakeup Broadcast Countdown Timer

This block is a memory-mapped countdown timer that wakes sleeping processors. Software writes a start value, picks single-expiry or auto-repeat behaviour and a 32-bit or 64-bit count width, and then sets the run bit. From then on the counter steps down once per pulse of a slow tick strobe. The strobe comes from a fixed 32.768 kHz source and is used as given, with no divider. When the count runs out, a sticky expiry flag sets. Gated by an enable bit, that flag drives a level interrupt line until software clears it.

Registers sit on a plain 32-bit bus made of a byte address, write and read strobes, write data and combinational read data. Every register is one word wide, and an access takes effect only when the low two address bits are zero. The start value can be written at any time, including while the timer is stopped. The count can be read live. Reading the live low word also takes a snapshot of the whole 64-bit count, so software can then read a high word that belongs with the low word it just read.

The counter is a three-state machine. Its states are `CT_OFF` (stopped), `CT_RUN` (counting) and `CT_DONE` (a single-expiry run has ended and the count is held at zero). It has these transitions:
- `OFF->RUN`: run bit seen set; the count loads from the start value.
- `RUN->RUN`: a tick either decrements the count or, in repeat mode, expires and reloads.
- `RUN->DONE`: a tick expires in single mode.
- `RUN->OFF` and `DONE->OFF`: run bit cleared.

Top module: `wake_timer`

Register map (byte offsets, word index = offset/4):

| Offset | Name | Access |
|---|---|---|
| 0x00 / 0x04 | start value, low / high word | read/write |
| 0x08 / 0x0C | live count, low / high word | read only |
| 0x10 | mode register | read/write |
| 0x14 | interrupt register | read/write |
| 0x18 / 0x1C | snapshot count, low / high word | read only |

## Requirements
- R1: After reset all eight registers read 0 and `irq_o` is 0.
- R2: Both start-value words read back what was written, including while stopped. Writes to the live-count and snapshot addresses change nothing.
- R3: In the mode register, bit 0 selects repeat, bit 1 runs and bit 16 selects 64-bit width. Once the run bit is set, the count loads from the start value within two clock edges. In 32-bit mode only the low start word is used and the live high word reads 0. The count drops by one per tick and holds when there is no tick.
- R4: In single mode, a start value N >= 1 expires on the Nth tick. At expiry the count becomes 0 and raw status (interrupt bit 1) sets. The count stays 0 through later ticks and through a rewrite of the run bit that is still set. It reloads only after the run bit is cleared and then set again.
- R5: In repeat mode, a start value N >= 1 expires every N ticks and reloads N, so after k ticks the count is N - (k mod N).
- R6: A start value of 0 expires on the first tick after the run bit is set.
- R7: The mode register reads back only bits 0, 1 and 16. Clearing the run bit freezes the count against ticks.
- R8: In the interrupt register, bit 0 is the interrupt enable and reads back as written. Bit 2 is raw AND enable, and `irq_o` equals bit 2. Writing 1 to bit 3 clears raw status, and bit 3 always reads 0.
- R9: When an expiry and a clear fall on the same clock edge, raw status stays set.
- R10: A read of offset 0x08 copies the full live count into the snapshot words on that edge. Later snapshot reads return that copy even after the count moves.
- R11: In 64-bit mode, a decrement from a low word of 0 borrows from the high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe from the 32.768 kHz time base |
| bus_addr | input | ADDR_W (5) | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (used for the snapshot) |
| bus_wdata | input | WORD_W (32) | Write data |
| bus_rdata | output | WORD_W (32) | Combinational read data |
| irq_o | output | 1 | Level interrupt, raw AND enable |

## Verification
An expiry on a tick and a software clear of raw status are the two functions that can land on the same edge. The bench provokes this with a repeat-mode start value of 2. After the first expiry it steps the count to 1, then drives the next tick in the same cycle as a write of the clear bit. It judges the result by reading raw status back as set and the count as reloaded. A second clear with no tick must then drop the flag.

// File: rtl/wkt_pkg.sv
`timescale 1ns/1ps
package wkt_pkg;
    // counter machine states
    typedef enum logic [1:0] {
        CT_OFF  = 2'd0,
        CT_RUN  = 2'd1,
        CT_DONE = 2'd2
    } ct_state_e;

    // word index of each register (byte offset / 4)
    localparam int IDX_W = 3;
    typedef logic [IDX_W-1:0] reg_idx_t;
    localparam reg_idx_t RI_START_LO = 3'd0;
    localparam reg_idx_t RI_START_HI = 3'd1;
    localparam reg_idx_t RI_LIVE_LO  = 3'd2;
    localparam reg_idx_t RI_LIVE_HI  = 3'd3;
    localparam reg_idx_t RI_MODE     = 3'd4;
    localparam reg_idx_t RI_IRQ      = 3'd5;
    localparam reg_idx_t RI_SNAP_LO  = 3'd6;
    localparam reg_idx_t RI_SNAP_HI  = 3'd7;

    // mode register bit positions
    localparam int MB_REPEAT = 0;
    localparam int MB_RUN    = 1;
    localparam int MB_WIDE   = 16;

    // interrupt register bit positions
    localparam int IB_ENABLE = 0;
    localparam int IB_RAW    = 1;
    localparam int IB_MASKED = 2;
    localparam int IB_CLEAR  = 3;
endpackage

// File: rtl/wkt_counter.sv
`timescale 1ns/1ps
module wkt_counter
    import wkt_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_i,
    input  logic                  repeat_i,
    input  logic                  wide_i,
    input  logic                  tick_i,
    input  logic [2*WORD_W-1:0]   start_i,
    output logic [2*WORD_W-1:0]   count_o,
    output logic                  expire_o
);
    localparam int CNT_W = 2 * WORD_W;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ct_state_e         state_q, state_d;
    logic [CNT_W-1:0]  count_q, count_d;
    logic [CNT_W-1:0]  cur;
    logic [CNT_W-1:0]  start_eff;
    logic              at_end;

    // width view: in narrow mode the upper word is treated as zero
    always_comb begin
        if (wide_i) begin
            cur       = count_q;
            start_eff = start_i;
        end else begin
            cur       = {{WORD_W{1'b0}}, count_q[WORD_W-1:0]};
            start_eff = {{WORD_W{1'b0}}, start_i[WORD_W-1:0]};
        end
        at_end = (cur <= ONE);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CT_OFF;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CT_OFF:  if (run_i) state_d = CT_RUN;
            CT_RUN: begin
                if (!run_i)                              state_d = CT_OFF;
                else if (tick_i && at_end && !repeat_i)  state_d = CT_DONE;
            end
            CT_DONE: if (!run_i) state_d = CT_OFF;
            default: state_d = CT_OFF;
        endcase
    end

    // outputs and count datapath
    always_comb begin
        count_d  = count_q;
        expire_o = 1'b0;
        unique case (state_q)
            CT_OFF:  if (run_i) count_d = start_eff;
            CT_RUN: begin
                if (run_i && tick_i) begin
                    if (at_end) begin
                        expire_o = 1'b1;
                        count_d  = repeat_i ? start_eff : '0;
                    end else begin
                        count_d  = cur - ONE;
                    end
                end
            end
            CT_DONE: count_d = '0;
            default: count_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count_o = cur;

    // R4: a finished single run holds the count at zero
    a_r4_done_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CT_DONE) |-> (count_q == '0));

    // R3: while running with no tick the count is held
    a_r3_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CT_RUN && run_i && !tick_i) |=> $stable(count_q));

    // R7: stopped and not started, the count is frozen
    a_r7_off_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CT_OFF && !run_i) |=> $stable(count_q));

    // R4: leaving RUN for DONE only happens on an expiry
    a_r4_done_by_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CT_RUN && state_d == CT_DONE) |-> expire_o);
endmodule

// File: rtl/wkt_irq.sv
`timescale 1ns/1ps
module wkt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic enable_bit_i,
    input  logic clear_bit_i,
    input  logic expire_i,
    output logic enable_o,
    output logic raw_o,
    output logic irq_o
);
    logic enable_q;
    logic raw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
            raw_q    <= 1'b0;
        end else begin
            if (wr_i) enable_q <= enable_bit_i;
            // a fresh expiry outranks a clear on the same edge
            if (expire_i)                 raw_q <= 1'b1;
            else if (wr_i && clear_bit_i) raw_q <= 1'b0;
        end
    end

    assign enable_o = enable_q;
    assign raw_o    = raw_q;
    assign irq_o    = raw_q & enable_q;

    // R9: an expiry always leaves raw status set
    a_r9_expire_wins: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> raw_q);

    // R8: a clear without an expiry drops raw status
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && clear_bit_i && !expire_i) |=> !raw_q);

    // R8: raw status only rises through an expiry
    a_r8_raw_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_q) |-> $past(expire_i));
endmodule

// File: rtl/wkt_regs.sv
`timescale 1ns/1ps
module wkt_regs
    import wkt_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic                  bus_re,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    input  logic [2*WORD_W-1:0]   count_i,
    input  logic                  irq_en_i,
    input  logic                  irq_raw_i,
    output logic [2*WORD_W-1:0]   start_o,
    output logic                  run_o,
    output logic                  repeat_o,
    output logic                  wide_o,
    output logic                  irq_wr_o
);
    localparam int CNT_W = 2 * WORD_W;

    logic              aligned;
    reg_idx_t          idx;
    logic [WORD_W-1:0] start_lo_q, start_hi_q;
    logic              run_q, repeat_q, wide_q;
    logic [CNT_W-1:0]  snap_q;
    logic              wr_hit, rd_hit;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign idx     = bus_addr[IDX_W+1:2];
    assign wr_hit  = bus_we && aligned;
    assign rd_hit  = bus_re && aligned;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_lo_q <= '0;
            start_hi_q <= '0;
            run_q      <= 1'b0;
            repeat_q   <= 1'b0;
            wide_q     <= 1'b0;
        end else if (wr_hit) begin
            unique case (idx)
                RI_START_LO: start_lo_q <= bus_wdata;
                RI_START_HI: start_hi_q <= bus_wdata;
                RI_MODE: begin
                    repeat_q <= bus_wdata[MB_REPEAT];
                    run_q    <= bus_wdata[MB_RUN];
                    wide_q   <= bus_wdata[MB_WIDE];
                end
                default: ;
            endcase
        end
    end

    // snapshot of the full count on a read of the live low word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          snap_q <= '0;
        else if (rd_hit && idx == RI_LIVE_LO) snap_q <= count_i;
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (idx)
                RI_START_LO: bus_rdata = start_lo_q;
                RI_START_HI: bus_rdata = start_hi_q;
                RI_LIVE_LO:  bus_rdata = count_i[WORD_W-1:0];
                RI_LIVE_HI:  bus_rdata = count_i[CNT_W-1:WORD_W];
                RI_MODE: begin
                    bus_rdata[MB_REPEAT] = repeat_q;
                    bus_rdata[MB_RUN]    = run_q;
                    bus_rdata[MB_WIDE]   = wide_q;
                end
                RI_IRQ: begin
                    bus_rdata[IB_ENABLE] = irq_en_i;
                    bus_rdata[IB_RAW]    = irq_raw_i;
                    bus_rdata[IB_MASKED] = irq_raw_i & irq_en_i;
                end
                RI_SNAP_LO:  bus_rdata = snap_q[WORD_W-1:0];
                RI_SNAP_HI:  bus_rdata = snap_q[CNT_W-1:WORD_W];
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign start_o  = {start_hi_q, start_lo_q};
    assign run_o    = run_q;
    assign repeat_o = repeat_q;
    assign wide_o   = wide_q;
    assign irq_wr_o = wr_hit && (idx == RI_IRQ);

    // R10: the snapshot holds the count seen on the latching read
    a_r10_snap_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && idx == RI_LIVE_LO) |=> (snap_q == $past(count_i)));

    // R10: without that read the snapshot does not move
    a_r10_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_hit && idx == RI_LIVE_LO) |=> $stable(snap_q));

    // R2: start words change only on a bus write
    a_r2_start_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(start_lo_q) && $stable(start_hi_q)));
endmodule

// File: rtl/wake_timer.sv
`timescale 1ns/1ps
module wake_timer
    import wkt_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int CNT_W = 2 * WORD_W;

    logic [CNT_W-1:0] start_w, count_w;
    logic             run_w, repeat_w, wide_w;
    logic             irq_wr_w, irq_en_w, irq_raw_w, expire_w;

    wkt_regs #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count_i   (count_w),
        .irq_en_i  (irq_en_w),
        .irq_raw_i (irq_raw_w),
        .start_o   (start_w),
        .run_o     (run_w),
        .repeat_o  (repeat_w),
        .wide_o    (wide_w),
        .irq_wr_o  (irq_wr_w)
    );

    wkt_counter #(.WORD_W(WORD_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_w),
        .repeat_i (repeat_w),
        .wide_i   (wide_w),
        .tick_i   (tick_i),
        .start_i  (start_w),
        .count_o  (count_w),
        .expire_o (expire_w)
    );

    wkt_irq u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (irq_wr_w),
        .enable_bit_i (bus_wdata[IB_ENABLE]),
        .clear_bit_i  (bus_wdata[IB_CLEAR]),
        .expire_i     (expire_w),
        .enable_o     (irq_en_w),
        .raw_o        (irq_raw_w),
        .irq_o        (irq_o)
    );

    // R3: in narrow mode the live high word is zero
    a_r3_narrow_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_w |-> (count_w[CNT_W-1:WORD_W] == '0));
endmodule

// File: tb/wake_timer_bench.sv
`timescale 1ns/1ps
module wake_timer_bench;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_i = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic              bus_re = 1'b0;
    logic [WORD_W-1:0] bus_wdata = '0;
    logic [WORD_W-1:0] bus_rdata;
    logic              irq_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    wake_timer #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_wake_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    localparam logic [4:0] A_ST_LO = 5'h00, A_ST_HI = 5'h04, A_LV_LO = 5'h08,
                           A_LV_HI = 5'h0C, A_MODE = 5'h10, A_IRQ = 5'h14,
                           A_SN_LO = 5'h18, A_SN_HI = 5'h1C;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr_tick(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1; tick_i = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick_i = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    function automatic logic [31:0] exp_count(input int unsigned s, input bit rep, input int unsigned k);
        if (rep) return (s == 0) ? 32'd0 : 32'(s - (k % s));
        return (k >= s) ? 32'd0 : 32'(s - k);
    endfunction

    function automatic bit exp_raw(input int unsigned s, input int unsigned k);
        return k >= ((s == 0) ? 1 : s);
    endfunction

    task automatic trial(input int unsigned s, input logic [31:0] hi, input bit rep,
                         input bit wide, input int unsigned k);
        logic [31:0] v;
        string tag;
        bit r;
        tag = rep ? "R5 repeat" : ((s == 0) ? "R6 zero start" : "R4 single");
        wr(A_MODE, 32'h0);
        wr(A_IRQ, 32'h9);
        wr(A_ST_LO, s);
        wr(A_ST_HI, wide ? 32'h0 : hi);
        wr(A_MODE, {15'h0, wide, 14'h0, 1'b1, rep});
        ticks(k);
        r = exp_raw(s, k);
        rd(A_LV_LO, v); check({tag, " count"}, v, exp_count(s, rep, k));
        rd(A_LV_HI, v); check("R3 high word", v, 32'h0);
        rd(A_IRQ, v);   check({tag, " status"}, v, r ? 32'h7 : 32'h1);
        check("R8 irq line", {31'h0, irq_o}, {31'h0, r});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), v); check("R1 reset reg", v, 32'h0);
        end
        check("R1 irq reset", {31'h0, irq_o}, 32'h0);

        // R2 start words and read-only addresses
        wr(A_ST_LO, 32'hA5A5_0001); wr(A_ST_HI, 32'h1234_5678);
        rd(A_ST_LO, v); check("R2 start lo", v, 32'hA5A5_0001);
        rd(A_ST_HI, v); check("R2 start hi", v, 32'h1234_5678);
        wr(A_LV_LO, 32'hFFFF_FFFF); wr(A_SN_HI, 32'hFFFF_FFFF);
        rd(A_LV_LO, v); check("R2 live ro", v, 32'h0);
        rd(A_SN_HI, v); check("R2 snap ro", v, 32'h0);

        // R7 mode readback
        wr(A_MODE, 32'hFFFF_FFFF);
        rd(A_MODE, v); check("R7 mode bits", v, 32'h0001_0003);
        wr(A_MODE, 32'h0);
        rd(A_MODE, v); check("R7 mode clear", v, 32'h0);

        // R3 narrow load, decrement, hold
        wr(A_ST_LO, 32'd5); wr(A_ST_HI, 32'd7);
        wr(A_MODE, 32'h2);
        rd(A_LV_LO, v); check("R3 load", v, 32'd5);
        rd(A_LV_HI, v); check("R3 narrow high", v, 32'd0);
        ticks(2);
        rd(A_LV_LO, v); check("R3 decrement", v, 32'd3);
        repeat (10) @(negedge clk);
        rd(A_LV_LO, v); check("R3 hold", v, 32'd3);
        wr(A_MODE, 32'h0);
        ticks(3);
        rd(A_LV_LO, v); check("R7 frozen", v, 32'd3);

        // R6 zero start, R8 status bits
        wr(A_IRQ, 32'h9);
        wr(A_ST_LO, 32'd0);
        wr(A_MODE, 32'h2);
        rd(A_IRQ, v); check("R6 not yet", v, 32'h1);
        ticks(1);
        rd(A_IRQ, v); check("R6 first tick", v, 32'h7);
        check("R8 irq high", {31'h0, irq_o}, 32'h1);
        wr(A_IRQ, 32'h0);
        rd(A_IRQ, v); check("R8 masked off", v, 32'h2);
        check("R8 irq masked", {31'h0, irq_o}, 32'h0);
        wr(A_IRQ, 32'h8);
        rd(A_IRQ, v); check("R8 clear reads 0", v, 32'h0);

        // R4 single run holds zero until restart
        wr(A_IRQ, 32'h9);
        wr(A_MODE, 32'h0);
        wr(A_ST_LO, 32'd4);
        wr(A_MODE, 32'h2);
        ticks(6);
        rd(A_LV_LO, v); check("R4 held zero", v, 32'd0);
        wr(A_MODE, 32'h2);
        ticks(1);
        rd(A_LV_LO, v); check("R4 no rearm", v, 32'd0);
        wr(A_MODE, 32'h0);
        wr(A_MODE, 32'h2);
        rd(A_LV_LO, v); check("R4 restart", v, 32'd4);

        // R9 expiry and clear on one edge
        wr(A_MODE, 32'h0);
        wr(A_IRQ, 32'h9);
        wr(A_ST_LO, 32'd2);
        wr(A_MODE, 32'h3);
        ticks(3);
        rd(A_LV_LO, v); check("R5 reload", v, 32'd1);
        wr_tick(A_IRQ, 32'h9);
        rd(A_IRQ, v); check("R9 expire wins", v, 32'h7);
        rd(A_LV_LO, v); check("R9 count", v, 32'd2);
        wr(A_IRQ, 32'h9);
        rd(A_IRQ, v); check("R9 later clear", v, 32'h1);

        // R10 snapshot, R11 borrow
        wr(A_MODE, 32'h0);
        wr(A_ST_LO, 32'd3); wr(A_ST_HI, 32'd5);
        wr(A_MODE, 32'h0001_0002);
        rd(A_LV_LO, v); check("R10 live lo", v, 32'd3);
        ticks(4);
        rd(A_SN_HI, v); check("R10 snap hi", v, 32'd5);
        rd(A_SN_LO, v); check("R10 snap lo", v, 32'd3);
        rd(A_LV_LO, v); check("R11 borrow lo", v, 32'hFFFF_FFFF);
        rd(A_SN_HI, v); check("R11 borrow snap hi", v, 32'd4);
        rd(A_LV_HI, v); check("R11 live hi", v, 32'd4);

        // random trials, R4 R5 R6
        for (int t = 0; t < 40; t++) begin
            trial($urandom_range(0, 20), $urandom, $urandom_range(0, 1),
                  $urandom_range(0, 1), $urandom_range(0, 30));
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule